// File: doc/BRIEF.md
# Read Data Compare and Error Counters

This block sits on the read return path of a memory test sequencer. On every beat marked valid, it compares the read data with the expected pattern data over nine byte lanes: eight data lanes and one ECC lane. A per-bit mask removes chosen bits from the compare. The results are kept in several forms:

- sticky error flags for each bit and each lane,
- a saturating error counter per lane and one global counter,
- the index of the data vector that held the first error.

On the first error of a sequence the block also raises a level error indication, which the sequencer uses for stop-on-error. When enabled, it also gives a single-cycle trigger pulse that can drive an external capture instrument.

A pulse on `seq_start` clears all state for a new sequence. A per-lane clear input drops the sticky flags of the selected lanes. The clear does not touch the counters or the first-error record.

Top module: `rdchk_top`

## Requirements
- R1: On a cycle with `beat_valid` high, bit k is in error when `rd_data[k] != exp_data[k]` and `cmp_mask[k]` is 0. A mask bit of 1 excludes that bit. Cycles with `beat_valid` low produce no error.
- R2: `bit_err[k]` is set by an error on bit k. It stays set until the lane holding bit k (lane = k/8, so lane i owns bits 8i+7..8i and lane 8 is ECC) is cleared through `lane_clr[i]`, or until a sequence start.
- R3: `lane_err[i]` is set when any bit of lane i is in error on a beat. `lane_clr[i]` clears it. If a clear and a new error arrive in the same cycle, the flag ends up set.
- R4: The counter for lane i in `lane_cnt[16i+15:16i]` adds one for each beat in which lane i has at least one error. It saturates at 0xFFFF and `lane_clr` does not affect it.
- R5: `glob_cnt` adds one for each beat in which any lane has an error. It saturates at 0xFFFF.
- R6: Valid beats are numbered from 0 after a sequence start, and the number saturates at 0xFFFF. `first_idx` holds the number of the first beat with an error. Later errors and lane clears leave it unchanged.
- R7: `err_seen` is low until the first error. It stays high from then until the next sequence start.
- R8: `trig_out` is a one-cycle pulse after the first error of a sequence, produced only if `trig_en` was high in that beat's cycle. Later errors give no pulse.
- R9: Reset and `seq_start` both clear every flag, counter, index and output to 0. A beat presented in the same cycle as `seq_start` is ignored.
- R10: All outputs are registered. A beat's effect appears after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Start of a new sequence; clears all state |
| beat_valid | input | 1 | Read beat present this cycle |
| rd_data | input | 72 | Returned read data, lane i at bits 8i+7..8i |
| exp_data | input | 72 | Expected pattern data |
| cmp_mask | input | 72 | 1 excludes the bit from the compare |
| lane_clr | input | 9 | Per-lane clear of the sticky flags |
| trig_en | input | 1 | Enables the first-error trigger pulse |
| bit_err | output | 72 | Sticky per-bit error flags |
| lane_err | output | 9 | Sticky per-lane error flags |
| lane_cnt | output | 144 | Per-lane 16-bit error counters, lane i at 16i+15..16i |
| glob_cnt | output | 16 | Global 16-bit error counter |
| first_idx | output | 16 | Beat number of the first error |
| err_seen | output | 1 | Error indication for stop-on-error |
| trig_out | output | 1 | One-cycle first-error trigger |

## Verification
The bench tests several corner cases, and each one has a typical failure:

- **Mismatch on a masked bit only.** A design that applies the mask wrongly counts it as an error.
- **Clear and new error on the same lane in the same cycle.** A design that gives the clear priority loses that error.
- **Sequence start together with a failing beat.** A careless design counts the beat into the new sequence.
- **First error on the ECC lane.** This catches lane-slicing mistakes at the top index.
- **Long run of failing beats.** Counters without saturation wrap to zero, and a first-index register that is not locked keeps tracking the latest error.
- **Repeated errors.** These show whether the trigger fires more than once per sequence.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;
  localparam int LANE_BITS = 8;
  typedef logic [LANE_BITS-1:0] lane_t;

  // bits that disagree and are not excluded by the mask
  function automatic lane_t miss_bits(input lane_t rd, input lane_t ex, input lane_t mask);
    return (rd ^ ex) & ~mask;
  endfunction
endpackage

// File: rtl/rdchk_satcnt.sv
module rdchk_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v, input logic up);
    if (up && (v != {W{1'b1}})) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sat_step(cnt, inc);
  end
endmodule

// File: rtl/rdchk_lane.sv
module rdchk_lane
  import rdchk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             beat,
  input  lane_t            rd,
  input  lane_t            ex,
  input  lane_t            mask,
  input  logic             clr_lane,
  output lane_t            bit_flags,
  output logic             lane_flag,
  output logic             lane_hit,
  output logic [CNT_W-1:0] cnt
);
  lane_t miss;

  assign miss     = beat ? miss_bits(rd, ex, mask) : '0;
  assign lane_hit = |miss;

  // a fresh error outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_flags <= '0;
      lane_flag <= 1'b0;
    end else if (clr_all) begin
      bit_flags <= '0;
      lane_flag <= 1'b0;
    end else begin
      bit_flags <= (clr_lane ? '0 : bit_flags) | miss;
      lane_flag <= (lane_flag & ~clr_lane) | lane_hit;
    end
  end

  rdchk_satcnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .inc   (lane_hit),
    .cnt   (cnt)
  );
endmodule

// File: rtl/rdchk_first.sv
module rdchk_first #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             beat,
  input  logic             any_hit,
  input  logic             trig_en,
  output logic [IDX_W-1:0] first_idx,
  output logic             err_seen,
  output logic             trig_out
);
  logic [IDX_W-1:0] vec_idx;
  logic             first_evt;

  assign first_evt = any_hit & ~err_seen;

  rdchk_satcnt #(.W(IDX_W)) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .inc   (beat),
    .cnt   (vec_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_idx <= '0;
      err_seen  <= 1'b0;
      trig_out  <= 1'b0;
    end else if (clr_all) begin
      first_idx <= '0;
      err_seen  <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      trig_out <= first_evt & trig_en;
      if (first_evt) begin
        first_idx <= vec_idx;
        err_seen  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdchk_top.sv
module rdchk_top
  import rdchk_pkg::*;
#(
  parameter int LANES = 9,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  localparam int DATA_W = LANES * LANE_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seq_start,
  input  logic                   beat_valid,
  input  logic [DATA_W-1:0]      rd_data,
  input  logic [DATA_W-1:0]      exp_data,
  input  logic [DATA_W-1:0]      cmp_mask,
  input  logic [LANES-1:0]       lane_clr,
  input  logic                   trig_en,
  output logic [DATA_W-1:0]      bit_err,
  output logic [LANES-1:0]       lane_err,
  output logic [LANES*CNT_W-1:0] lane_cnt,
  output logic [CNT_W-1:0]       glob_cnt,
  output logic [IDX_W-1:0]       first_idx,
  output logic                   err_seen,
  output logic                   trig_out
);
  logic             beat;
  logic [LANES-1:0] lane_hit;
  logic             beat_hit;

  // a beat arriving with the start pulse belongs to no sequence
  assign beat     = beat_valid & ~seq_start;
  assign beat_hit = |lane_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rdchk_lane #(.CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all   (seq_start),
      .beat      (beat),
      .rd        (rd_data[i*LANE_BITS +: LANE_BITS]),
      .ex        (exp_data[i*LANE_BITS +: LANE_BITS]),
      .mask      (cmp_mask[i*LANE_BITS +: LANE_BITS]),
      .clr_lane  (lane_clr[i]),
      .bit_flags (bit_err[i*LANE_BITS +: LANE_BITS]),
      .lane_flag (lane_err[i]),
      .lane_hit  (lane_hit[i]),
      .cnt       (lane_cnt[i*CNT_W +: CNT_W])
    );
  end

  rdchk_satcnt #(.W(CNT_W)) u_glob (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (seq_start),
    .inc   (beat_hit),
    .cnt   (glob_cnt)
  );

  rdchk_first #(.IDX_W(IDX_W)) u_first (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (seq_start),
    .beat      (beat),
    .any_hit   (beat_hit),
    .trig_en   (trig_en),
    .first_idx (first_idx),
    .err_seen  (err_seen),
    .trig_out  (trig_out)
  );
endmodule

// File: rtl/rdchk_sva.sv
module rdchk_sva #(
  parameter int LANES = 9,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_start,
  input logic             beat_hit,
  input logic [LANES-1:0] lane_err,
  input logic [CNT_W-1:0] glob_cnt,
  input logic [IDX_W-1:0] first_idx,
  input logic             err_seen,
  input logic             trig_out
);
  // R5
  glob_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_hit && glob_cnt != {CNT_W{1'b1}}) |=> glob_cnt == CNT_W'($past(glob_cnt) + 1'b1));
  // R5
  glob_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_cnt == {CNT_W{1'b1}} && !seq_start) |=> glob_cnt == {CNT_W{1'b1}});
  // R5
  glob_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_start |=> glob_cnt >= $past(glob_cnt));
  // R6
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seen && !seq_start) |=> $stable(first_idx));
  // R7
  seen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seen && !seq_start) |=> err_seen);
  // R8
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  // R8
  trig_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> err_seen);
  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (glob_cnt == '0 && lane_err == '0 && !err_seen && !trig_out));
endmodule

bind rdchk_top rdchk_sva #(.LANES(LANES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .seq_start (seq_start),
  .beat_hit  (beat_hit),
  .lane_err  (lane_err),
  .glob_cnt  (glob_cnt),
  .first_idx (first_idx),
  .err_seen  (err_seen),
  .trig_out  (trig_out)
);

// File: tb/test_rdchk_top.sv
`timescale 1ns/1ps
module test_rdchk_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         seq_start = 0, beat_valid = 0, trig_en = 0;
  logic [71:0]  rd_data = '0, exp_data = '0, cmp_mask = '0;
  logic [8:0]   lane_clr = '0;
  logic [71:0]  bit_err;
  logic [8:0]   lane_err;
  logic [143:0] lane_cnt;
  logic [15:0]  glob_cnt, first_idx;
  logic         err_seen, trig_out;

  always #2.5 clk = ~clk;

  rdchk_top i_rdchk_top (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .beat_valid(beat_valid),
    .rd_data(rd_data), .exp_data(exp_data), .cmp_mask(cmp_mask), .lane_clr(lane_clr),
    .trig_en(trig_en), .bit_err(bit_err), .lane_err(lane_err), .lane_cnt(lane_cnt),
    .glob_cnt(glob_cnt), .first_idx(first_idx), .err_seen(err_seen), .trig_out(trig_out)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference state
  logic [71:0] m_bits;
  logic [8:0]  m_lane;
  int          m_lcnt [9];
  int          m_glob, m_vec, m_first;
  bit          m_seen, m_trig;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    return (v < 65535) ? v + 1 : v;
  endfunction

  task automatic model_clear();
    m_bits = '0; m_lane = '0; m_glob = 0; m_vec = 0; m_first = 0;
    m_seen = 0; m_trig = 0;
    for (int l = 0; l < 9; l++) m_lcnt[l] = 0;
  endtask

  task automatic compare_all();
    chk("R2 bit flags", 128'(bit_err), 128'(m_bits));
    chk("R3 lane flags", 128'(lane_err), 128'(m_lane));
    for (int l = 0; l < 9; l++)
      chk("R4 lane counter", 128'(lane_cnt[16*l +: 16]), 128'(m_lcnt[l]));
    chk("R5 global counter", 128'(glob_cnt), 128'(m_glob));
    chk("R6 first index", 128'(first_idx), 128'(m_first));
    chk("R7 error seen", 128'(err_seen), 128'(m_seen));
    chk("R8 trigger", 128'(trig_out), 128'(m_trig));
  endtask

  task automatic step(bit v, logic [71:0] rd, logic [71:0] ex, logic [71:0] mk,
                      logic [8:0] clr, bit st, bit te, bit do_chk, bit pre);
    logic [71:0] miss;
    bit any;
    @(negedge clk);
    beat_valid = v; rd_data = rd; exp_data = ex; cmp_mask = mk;
    lane_clr = clr; seq_start = st; trig_en = te;
    if (pre) begin
      #1;
      chk("R10 no early change", 128'(glob_cnt), 128'(m_glob));
      chk("R10 no early flag", 128'(err_seen), 128'(m_seen));
    end
    if (st) model_clear();
    else begin
      any = 0;
      for (int k = 0; k < 72; k++) miss[k] = v && (rd[k] != ex[k]) && !mk[k];
      for (int l = 0; l < 9; l++) begin
        logic [7:0] lm;
        lm = miss[8*l +: 8];
        m_bits[8*l +: 8] = (clr[l] ? 8'h00 : m_bits[8*l +: 8]) | lm;
        m_lane[l] = (m_lane[l] & ~clr[l]) | (lm != 0);
        if (lm != 0) begin m_lcnt[l] = sat16(m_lcnt[l]); any = 1; end
      end
      m_trig = any && !m_seen && te;
      if (any) begin
        m_glob = sat16(m_glob);
        if (!m_seen) begin m_first = m_vec; m_seen = 1; end
      end
      if (v) m_vec = sat16(m_vec);
    end
    @(posedge clk); #1;
    if (do_chk) compare_all();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [71:0] base;
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R9 reset state
    chk("R9 reset counter", 128'(glob_cnt), 0);
    chk("R9 reset flags", 128'({bit_err, lane_err, err_seen, trig_out}), 0);

    base = 72'hA5_5A3C_C3F0_0F12_3456;
    // R1 masked-only mismatch is no error; idle cycle with mismatch ignored
    step(1, base ^ 72'h1, base, 72'h1, '0, 0, 1, 1, 0);
    chk("R1 masked bit", 128'(glob_cnt), 0);
    step(0, base ^ 72'hFF, base, '0, '0, 0, 1, 1, 0);
    chk("R1 invalid beat", 128'(lane_err), 0);
    // first error on ECC lane bit 70, with latency probe (R10)
    step(1, base ^ (72'h1 << 70), base, '0, '0, 0, 1, 1, 1);
    chk("R6 first at beat 1", 128'(first_idx), 1);
    chk("R8 pulse on first", 128'(trig_out), 1);
    // later error: no new trigger, index locked
    step(1, base ^ 72'h300, base, '0, '0, 0, 1, 1, 0);
    chk("R8 no second pulse", 128'(trig_out), 0);
    // clear and new error on lane 1 in one cycle: set wins
    step(1, base ^ 72'h400, base, '0, 9'h002, 0, 0, 1, 0);
    chk("R3 set beats clear", 128'(lane_err[1]), 1);
    // clear of ECC lane without error
    step(0, base, base, '0, 9'h100, 0, 0, 1, 0);
    chk("R2 ecc bits cleared", 128'(bit_err[71:64]), 0);
    chk("R4 counter kept", 128'(lane_cnt[143:128]), 1);
    // start together with a failing beat: beat ignored
    step(1, ~base, base, '0, '0, 1, 1, 1, 0);
    chk("R9 start clears", 128'({glob_cnt, lane_err, err_seen}), 0);
    // first error with trigger disabled
    step(1, base ^ 72'h10, base, '0, '0, 0, 0, 1, 0);
    chk("R8 disabled trigger", 128'(trig_out), 0);
    chk("R7 seen set", 128'(err_seen), 1);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [71:0] ex, flip, mk;
      ex   = {$urandom, $urandom, $urandom};
      flip = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
           & {$urandom, $urandom, $urandom};
      if ($urandom % 3 == 0) flip = '0;
      mk   = ($urandom % 2) ? ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}) : '0;
      step(($urandom % 4) != 0, ex ^ flip, ex, mk,
           (($urandom % 5) == 0) ? 9'($urandom) : 9'h0,
           ($urandom % 97) == 0, $urandom % 2, 1, 0);
    end

    // saturation run on lane 0
    step(0, '0, '0, '0, '0, 1, 0, 1, 0);
    for (int n = 0; n < 65540; n++) step(1, 72'h1, 72'h0, '0, '0, 0, 0, 0, 0);
    compare_all();
    chk("R4 lane 0 saturates", 128'(lane_cnt[15:0]), 128'(16'hFFFF));
    chk("R5 global saturates", 128'(glob_cnt), 128'(16'hFFFF));
    chk("R6 index locked at 0", 128'(first_idx), 0);

    @(negedge clk); beat_valid = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule